// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric. Each channel reports an expiry as a one-cycle event, and the router turns it into an interrupt request. A channel can signal by level, which sets a status bit and holds a request line high until software acknowledges it. It can signal by edge, which gives a single-cycle pulse and sets no status. It can also signal by message, which uses no line at all and emits a 32-bit address/data pair taken from the channel's message registers. A request line that several sources drive carries the OR of all of them.

A compatibility mode ties channels 0 and 1 to lines 0 and 8, whatever their route fields say. The same mode blocks two external legacy interrupt inputs, a periodic-tick input and a clock-alarm input, which otherwise reach lines 0 and 8 through one register stage. Software acknowledges level interrupts by writing ones to the status bits. The global enable and the per-channel enables gate everything.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset, `status`, all `irq_lines` and `msg_valid` are 0, and `pit_enable` is 1 while `legacy_mode` is 0.
- R2: A level-mode channel (`ch_level`=1, `ch_msg_en`=0, channel and global enable on) whose `expire` is sampled high has its `status` bit set from the next cycle. Its routed line stays high until the bit is cleared.
- R3: An edge-mode channel (`ch_level`=0) drives its routed line high for exactly the one cycle after the expiry is sampled, and its `status` bit stays 0.
- R4: Writing `sts_wr_en`=1 with a 1 in bit i of `sts_wr_data` clears status bit i and drops that channel's contribution from the next cycle. A 0 in bit i has no effect. An expiry of channel i in the same cycle wins, and the bit stays set.
- R5: While `glb_en` or `ch_en[i]` is 0, channel i contributes to no line and sends no message, and its status bit reads 0 from the next cycle on.
- R6: Channel i's route field is `ch_route[i*ROUTE_W +: ROUTE_W]` and selects line index = field value. A value of `NUM_LINES` or more drives no line. Each line is the OR of every source routed to it.
- R7: With `legacy_mode`=1, channel 0 drives line `LEG_LINE_A` (0) and channel 1 drives line `LEG_LINE_B` (8), whatever their route fields say. The other channels keep their route fields.
- R8: With `legacy_mode`=0, `pit_in` reaches line 0 and `rtc_in` reaches line 8, each one cycle late. With `legacy_mode`=1 both are blocked and `pit_enable` is 0.
- R9: In the first cycle after `legacy_mode` falls, line 0 is low from the tick input, `pit_enable` is 1, and line 8 shows the clock-alarm level sampled on the last edge. From the cycle after that, line 0 follows `pit_in` again.
- R10: A message-mode channel sets no status and drives no line. An expiry gives one `msg_valid` cycle two cycles after it is sampled, carrying that channel's `ch_msg_addr`/`ch_msg_data` slices. When several channels are pending, the lowest index is sent first, one per cycle.
- R11: Setting `ch_msg_en[i]` clears a pending level status bit of channel i and its line from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy_mode | input | 1 | Compatibility routing mode |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_level | input | NUM_CH | 1 = level signalling, 0 = edge |
| ch_msg_en | input | NUM_CH | Message delivery instead of a line |
| ch_route | input | NUM_CH*ROUTE_W | Route field per channel |
| ch_msg_addr | input | NUM_CH*32 | Message address per channel |
| ch_msg_data | input | NUM_CH*32 | Message data per channel |
| expire | input | NUM_CH | One-cycle expiry events |
| sts_wr_en | input | 1 | Status write strobe |
| sts_wr_data | input | NUM_CH | Write-one-to-clear mask |
| pit_in | input | 1 | Legacy periodic-tick interrupt input |
| rtc_in | input | 1 | Legacy clock-alarm interrupt input |
| irq_lines | output | NUM_LINES | Interrupt request lines |
| pit_enable | output | 1 | Low while compatibility mode blocks the tick source |
| status | output | NUM_CH | Level interrupt status |
| msg_valid | output | 1 | Message request strobe |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench goes after acknowledge collisions. A write-one that meets an expiry in the same cycle must leave the bit set; a design that let the clear win would lose an interrupt. A write of zero must change nothing; a design that cleared on any write would drop pending work. Two channels share one line, and the bench clears one of them. A design that drove the line from only the last channel would drop it early. The bench also moves in and out of compatibility mode with both legacy inputs held high. A wrong design would let the tick leak onto line 0 during the first cycle after leaving the mode, or would lose the sampled alarm level. The bench checks message order when two channels fire together. It also checks that turning on message mode clears a level bit, since a stale bit would keep a line asserted for a channel that no longer owns one.

// File: rtl/tmr_irq_pkg.sv
// Package: shared types for the timer interrupt router.
// Assumes message address and data are both 32 bits wide.
package tmr_irq_pkg;
    localparam int MSG_W = 32;

    typedef struct packed {
        logic [MSG_W-1:0] addr;
        logic [MSG_W-1:0] data;
    } irq_msg_t;
endpackage

// File: rtl/irq_chan_slot.sv
// Per-channel state: level status, edge pulse and pending message.
// Assumes expire is a single-cycle event and clr is already masked per channel.
module irq_chan_slot (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic level_mode,
    input  logic msg_mode,
    input  logic expire,
    input  logic clr,
    input  logic grant,
    output logic status_q,
    output logic pulse_q,
    output logic pend_q,
    output logic drive
);
    // Level status: expiry sets it, write-one clears it, disable or message mode clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (!active || msg_mode)
            status_q <= 1'b0;
        else if (expire && level_mode)
            status_q <= 1'b1;
        else if (clr)
            status_q <= 1'b0;
    end

    // Edge pulse: high for one cycle after an edge-mode expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= active && !msg_mode && expire && !level_mode;
    end

    // Pending message: set on a message-mode expiry, dropped when granted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (!active || !msg_mode)
            pend_q <= 1'b0;
        else if (expire)
            pend_q <= 1'b1;
        else if (grant)
            pend_q <= 1'b0;
    end

    // Line contribution, gated at once by the current enables.
    always_comb drive = (status_q || pulse_q) && active && !msg_mode;
endmodule

// File: rtl/irq_legacy_pass.sv
// Legacy input pass-through: registers the tick and alarm inputs and blocks them in compatibility mode.
// Assumes both inputs are synchronous to clk.
module irq_legacy_pass (
    input  logic clk,
    input  logic rst_n,
    input  logic legacy_mode,
    input  logic pit_in,
    input  logic rtc_in,
    output logic pit_pass,
    output logic rtc_pass,
    output logic pit_enable
);
    logic pit_q;
    logic rtc_q;
    logic legacy_q;

    // Tick sample: held low in the mode and for one cycle after leaving it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pit_q    <= 1'b0;
            legacy_q <= 1'b0;
        end else begin
            pit_q    <= (legacy_mode || legacy_q) ? 1'b0 : pit_in;
            legacy_q <= legacy_mode;
        end
    end

    // Alarm sample: always tracked so the last level is ready when the mode ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rtc_q <= 1'b0;
        else
            rtc_q <= rtc_in;
    end

    // Outputs gated by the current mode.
    always_comb begin
        pit_pass   = pit_q && !legacy_mode;
        rtc_pass   = rtc_q && !legacy_mode;
        pit_enable = !legacy_mode;
    end
endmodule

// File: rtl/irq_line_merge.sv
// Line merge: maps each channel's contribution onto a line and ORs all sources.
// Assumes route values at or above NUM_LINES select no line.
module irq_line_merge #(
    parameter int NUM_CH     = 4,
    parameter int NUM_LINES  = 12,
    parameter int ROUTE_W    = 4,
    parameter int LEG_LINE_A = 0,
    parameter int LEG_LINE_B = 8
) (
    input  logic [NUM_CH-1:0]         drive,
    input  logic [NUM_CH*ROUTE_W-1:0] route,
    input  logic                      legacy_mode,
    input  logic                      pit_pass,
    input  logic                      rtc_pass,
    output logic [NUM_LINES-1:0]      lines
);
    logic [NUM_CH*ROUTE_W-1:0] eff_route;

    // Effective route: compatibility mode overrides channels 0 and 1.
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_route
            if (c == 0) begin : g_a
                assign eff_route[c*ROUTE_W +: ROUTE_W] =
                    legacy_mode ? ROUTE_W'(LEG_LINE_A) : route[c*ROUTE_W +: ROUTE_W];
            end else if (c == 1) begin : g_b
                assign eff_route[c*ROUTE_W +: ROUTE_W] =
                    legacy_mode ? ROUTE_W'(LEG_LINE_B) : route[c*ROUTE_W +: ROUTE_W];
            end else begin : g_n
                assign eff_route[c*ROUTE_W +: ROUTE_W] = route[c*ROUTE_W +: ROUTE_W];
            end
        end
    endgenerate

    // OR every routed source and the legacy pass-through onto the lines.
    always_comb begin
        lines = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (drive[c] && (int'(eff_route[c*ROUTE_W +: ROUTE_W]) == l))
                    lines[l] = 1'b1;
            end
        end
        lines[LEG_LINE_A] = lines[LEG_LINE_A] | pit_pass;
        lines[LEG_LINE_B] = lines[LEG_LINE_B] | rtc_pass;
    end
endmodule

// File: rtl/irq_msg_arb.sv
// Message arbiter: sends one pending channel per cycle, lowest index first.
// Assumes pending bits stay up until their grant.
module irq_msg_arb
    import tmr_irq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       pend,
    input  logic [NUM_CH*MSG_W-1:0] addr_in,
    input  logic [NUM_CH*MSG_W-1:0] data_in,
    output logic [NUM_CH-1:0]       grant,
    output logic                    msg_valid,
    output irq_msg_t                msg_out
);
    irq_msg_t sel;

    // Priority pick: lowest pending index wins.
    always_comb begin
        grant = '0;
        sel   = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (pend[c]) begin
                grant    = '0;
                grant[c] = 1'b1;
                sel.addr = addr_in[c*MSG_W +: MSG_W];
                sel.data = data_in[c*MSG_W +: MSG_W];
            end
        end
    end

    // Output register: one message strobe per grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_out   <= '0;
        end else begin
            msg_valid <= |pend;
            msg_out   <= sel;
        end
    end
endmodule

// File: rtl/tmr_irq_router.sv
// Top: routes timer expiry events to interrupt lines, status bits or messages.
// Assumes all inputs are synchronous to clk; status acknowledge is write-one-to-clear.
module tmr_irq_router
    import tmr_irq_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int NUM_LINES  = 12,
    parameter int LEG_LINE_A = 0,
    parameter int LEG_LINE_B = 8,
    localparam int ROUTE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      glb_en,
    input  logic                      legacy_mode,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [NUM_CH-1:0]         ch_level,
    input  logic [NUM_CH-1:0]         ch_msg_en,
    input  logic [NUM_CH*ROUTE_W-1:0] ch_route,
    input  logic [NUM_CH*MSG_W-1:0]   ch_msg_addr,
    input  logic [NUM_CH*MSG_W-1:0]   ch_msg_data,
    input  logic [NUM_CH-1:0]         expire,
    input  logic                      sts_wr_en,
    input  logic [NUM_CH-1:0]         sts_wr_data,
    input  logic                      pit_in,
    input  logic                      rtc_in,
    output logic [NUM_LINES-1:0]      irq_lines,
    output logic                      pit_enable,
    output logic [NUM_CH-1:0]         status,
    output logic                      msg_valid,
    output logic [MSG_W-1:0]          msg_addr,
    output logic [MSG_W-1:0]          msg_data
);
    logic [NUM_CH-1:0] drive;
    logic [NUM_CH-1:0] pulse;
    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] grant;
    logic              pit_pass;
    logic              rtc_pass;
    irq_msg_t          msg_q;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            irq_chan_slot u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .active     (glb_en && ch_en[c]),
                .level_mode (ch_level[c]),
                .msg_mode   (ch_msg_en[c]),
                .expire     (expire[c]),
                .clr        (sts_wr_en && sts_wr_data[c]),
                .grant      (grant[c]),
                .status_q   (status[c]),
                .pulse_q    (pulse[c]),
                .pend_q     (pend[c]),
                .drive      (drive[c])
            );
        end
    endgenerate

    irq_legacy_pass u_legacy (
        .clk         (clk),
        .rst_n       (rst_n),
        .legacy_mode (legacy_mode),
        .pit_in      (pit_in),
        .rtc_in      (rtc_in),
        .pit_pass    (pit_pass),
        .rtc_pass    (rtc_pass),
        .pit_enable  (pit_enable)
    );

    irq_line_merge #(
        .NUM_CH     (NUM_CH),
        .NUM_LINES  (NUM_LINES),
        .ROUTE_W    (ROUTE_W),
        .LEG_LINE_A (LEG_LINE_A),
        .LEG_LINE_B (LEG_LINE_B)
    ) u_merge (
        .drive       (drive),
        .route       (ch_route),
        .legacy_mode (legacy_mode),
        .pit_pass    (pit_pass),
        .rtc_pass    (rtc_pass),
        .lines       (irq_lines)
    );

    irq_msg_arb #(
        .NUM_CH (NUM_CH)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .addr_in   (ch_msg_addr),
        .data_in   (ch_msg_data),
        .grant     (grant),
        .msg_valid (msg_valid),
        .msg_out   (msg_q)
    );

    // Message fields out of the arbiter register.
    always_comb begin
        msg_addr = msg_q.addr;
        msg_data = msg_q.data;
    end

    // The edge pulse is only observed through drive; keep it referenced.
    logic pulse_any;
    always_comb pulse_any = |pulse;
    logic unused_ok;
    always_comb unused_ok = pulse_any;
endmodule

// File: rtl/tmr_irq_router_chk.sv
// Checker: status-bit properties of the interrupt router, bound to the top.
// Assumes the top's port names.
module tmr_irq_router_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glb_en,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] ch_level,
    input logic [NUM_CH-1:0] ch_msg_en,
    input logic [NUM_CH-1:0] expire,
    input logic              sts_wr_en,
    input logic [NUM_CH-1:0] sts_wr_data,
    input logic [NUM_CH-1:0] status
);
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_p
            p_level_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (glb_en && ch_en[i] && !ch_msg_en[i] && ch_level[i] && expire[i]) |=> status[i]);
            p_edge_nostat_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!ch_level[i] && expire[i] && !status[i]) |=> !status[i]);
            p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (sts_wr_en && sts_wr_data[i] && !expire[i]) |=> !status[i]);
            p_w0_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (sts_wr_en && !sts_wr_data[i] && status[i] && glb_en && ch_en[i] && !ch_msg_en[i])
                |=> status[i]);
            p_off_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!glb_en || !ch_en[i]) |=> !status[i]);
            p_msg_nostat_r11: assert property (@(posedge clk) disable iff (!rst_n)
                ch_msg_en[i] |=> !status[i]);
        end
    endgenerate
endmodule

bind tmr_irq_router tmr_irq_router_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_en      (glb_en),
    .ch_en       (ch_en),
    .ch_level    (ch_level),
    .ch_msg_en   (ch_msg_en),
    .expire      (expire),
    .sts_wr_en   (sts_wr_en),
    .sts_wr_data (sts_wr_data),
    .status      (status)
);

// File: tb/tb_tmr_irq_router.sv
module tb_tmr_irq_router;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NL  = 12;
    localparam int RW  = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            glb_en, legacy_mode;
    logic [NCH-1:0]  ch_en, ch_level, ch_msg_en, expire, sts_wr_data;
    logic [NCH*RW-1:0] ch_route;
    logic [NCH*32-1:0] ch_msg_addr, ch_msg_data;
    logic            sts_wr_en, pit_in, rtc_in;
    logic [NL-1:0]   irq_lines;
    logic            pit_enable, msg_valid;
    logic [NCH-1:0]  status;
    logic [31:0]     msg_addr, msg_data;

    int total = 0;
    int bad   = 0;
    logic [63:0] exp_q[$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_irq_router #(.NUM_CH(NCH), .NUM_LINES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_mode(legacy_mode),
        .ch_en(ch_en), .ch_level(ch_level), .ch_msg_en(ch_msg_en), .ch_route(ch_route),
        .ch_msg_addr(ch_msg_addr), .ch_msg_data(ch_msg_data), .expire(expire),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data), .pit_in(pit_in), .rtc_in(rtc_in),
        .irq_lines(irq_lines), .pit_enable(pit_enable), .status(status),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fire(input logic [NCH-1:0] m);
        expire = m;
        step();
        expire = '0;
    endtask

    task automatic ack(input logic [NCH-1:0] m);
        sts_wr_en = 1'b1;
        sts_wr_data = m;
        step();
        sts_wr_en = 1'b0;
        sts_wr_data = '0;
    endtask

    task automatic set_route(input int c, input int r);
        ch_route[c*RW +: RW] = RW'(r);
    endtask

    // Scoreboard driver side: queue the message a channel is expected to send.
    task automatic expect_msg(input int c);
        exp_q.push_back({ch_msg_addr[c*32 +: 32], ch_msg_data[c*32 +: 32]});
    endtask

    // Scoreboard monitor: compares every message strobe with the queue head (R10).
    always @(negedge clk) begin
        if (rst_n && msg_valid) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected message", {msg_addr, msg_data}, 64'h0);
                if ({msg_addr, msg_data} == 64'h0) begin
                    bad++;
                    $display("FAIL R10 actual=message expected=none");
                end
            end else begin
                chk("R10 message content", {msg_addr, msg_data}, exp_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; glb_en = 1'b0; legacy_mode = 1'b0;
        ch_en = '0; ch_level = '0; ch_msg_en = '0; expire = '0;
        sts_wr_en = 1'b0; sts_wr_data = '0; pit_in = 1'b0; rtc_in = 1'b0;
        ch_route = '0;
        for (int c = 0; c < NCH; c++) begin
            ch_msg_addr[c*32 +: 32] = 32'hFEE0_0000 + 32'(c * 16);
            ch_msg_data[c*32 +: 32] = 32'h0000_4000 + 32'(c);
        end
        step(); step();
        rst_n = 1'b1;
        step();
        chk("R1 status", 64'(status), 64'h0);
        chk("R1 lines", 64'(irq_lines), 64'h0);
        chk("R1 msg_valid", 64'(msg_valid), 64'h0);
        chk("R1 pit_enable", 64'(pit_enable), 64'h1);

        glb_en = 1'b1; ch_en = '1;
        set_route(0, 3); set_route(1, 4); set_route(2, 5); set_route(3, 6);

        // R2: level channel 2 to line 5.
        ch_level = 4'b0100;
        fire(4'b0100);
        chk("R2 status set", 64'(status), 64'h4);
        chk("R2 line high", 64'(irq_lines), 64'h20);
        step();
        chk("R2 line held", 64'(irq_lines), 64'h20);

        // R4: write zero keeps, write one clears.
        ack(4'b0000);
        chk("R4 write zero ignored", 64'(status), 64'h4);
        ack(4'b0100);
        chk("R4 write one clears status", 64'(status), 64'h0);
        chk("R4 write one drops line", 64'(irq_lines), 64'h0);

        // R3: edge channel 3 to line 6.
        fire(4'b1000);
        chk("R3 pulse high", 64'(irq_lines), 64'h40);
        chk("R3 no status", 64'(status), 64'h0);
        step();
        chk("R3 pulse one cycle", 64'(irq_lines), 64'h0);

        // R6: two level channels share line 7.
        ch_level = 4'b1100; set_route(2, 7); set_route(3, 7);
        fire(4'b1100);
        ack(4'b0100);
        chk("R6 shared line stays up", 64'(irq_lines), 64'h80);
        ack(4'b1000);
        chk("R6 shared line falls", 64'(irq_lines), 64'h0);
        // R6: route beyond the last line drives nothing.
        set_route(2, 13);
        fire(4'b0100);
        chk("R6 out-of-range status", 64'(status), 64'h4);
        chk("R6 out-of-range no line", 64'(irq_lines), 64'h0);

        // R4: set wins over a same-cycle clear.
        sts_wr_en = 1'b1; sts_wr_data = 4'b0100; expire = 4'b0100;
        step();
        sts_wr_en = 1'b0; sts_wr_data = '0; expire = '0;
        chk("R4 expiry beats clear", 64'(status), 64'h4);

        // R5: global disable clears; channel disable blocks.
        set_route(2, 5);
        glb_en = 1'b0;
        step();
        chk("R5 global off status", 64'(status), 64'h0);
        chk("R5 global off lines", 64'(irq_lines), 64'h0);
        glb_en = 1'b1; ch_en = 4'b1011;
        fire(4'b0100);
        chk("R5 channel off status", 64'(status), 64'h0);
        chk("R5 channel off lines", 64'(irq_lines), 64'h0);
        ch_en = '1;

        // R8: pass-through with compatibility mode off.
        pit_in = 1'b1; rtc_in = 1'b1;
        step();
        chk("R8 pass lines 0 and 8", 64'(irq_lines), 64'h101);
        legacy_mode = 1'b1;
        step();
        chk("R8 blocked in mode", 64'(irq_lines), 64'h0);
        chk("R8 pit_enable low", 64'(pit_enable), 64'h0);

        // R7: channel 0 forced to line 0, channel 1 to line 8.
        ch_level = 4'b0001;
        fire(4'b0001);
        chk("R7 ch0 on line 0 not 3", 64'(irq_lines), 64'h1);
        ack(4'b0001);
        fire(4'b0010);
        chk("R7 ch1 pulse on line 8", 64'(irq_lines), 64'h100);
        step();
        chk("R7 other channel keeps route", 64'(irq_lines), 64'h0);

        // R9: leaving the mode with both inputs high.
        legacy_mode = 1'b0;
        step();
        chk("R9 pit_enable high", 64'(pit_enable), 64'h1);
        chk("R9 line 0 low line 8 alarm", 64'(irq_lines), 64'h100);
        step();
        chk("R9 tick resumes", 64'(irq_lines), 64'h101);
        pit_in = 1'b0; rtc_in = 1'b0;
        step();

        // R10: message channel 1, then channels 0 and 3 together.
        ch_msg_en = 4'b1011;
        step();
        expect_msg(1);
        fire(4'b0010);
        chk("R10 no status", 64'(status), 64'h0);
        chk("R10 no line", 64'(irq_lines), 64'h0);
        step(); step();
        chk("R10 single message sent", 64'(exp_q.size()), 64'h0);
        expect_msg(0);
        expect_msg(3);
        fire(4'b1001);
        step(); step(); step();
        chk("R10 both messages in order", 64'(exp_q.size()), 64'h0);
        ch_msg_en = '0;

        // R11: message mode clears a pending level bit.
        ch_level = 4'b0100;
        fire(4'b0100);
        chk("R11 precondition set", 64'(status), 64'h4);
        ch_msg_en = 4'b0100;
        step();
        chk("R11 status cleared", 64'(status), 64'h0);
        chk("R11 line cleared", 64'(irq_lines), 64'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule